// File: doc/BRIEF.md
# Two-Rail Serial Word Receive Channel

This block is one receive channel for a two-rail, return-to-zero serial line of the kind used on avionics data buses. A data one is a pulse on rail A and a data zero is a pulse on rail B. Each pulse fills roughly the first half of its bit time, and both rails stay low for the rest of the bit. The channel takes its rails from either an external line receiver or a wrap-around test path. It samples the rails ten times per nominal bit, confirms each bit, and assembles words of 32 or 25 bits with the first received bit in bit position 0. A word must be framed by idle time before and after it.

A completed word can be filtered on a two-bit code carried in serial bits 9 and 10. An accepted word goes into a holding buffer and pulls the active-low ready flag low. A host reads the buffer as two 16-bit halves, using a select line and an active-low output enable, and it can read a parity status bit at any time. If a word arrives while the buffer still holds unread data, the new word waits in a side register. The next accepted word overwrites it. It moves into the buffer once the host has read both halves.

Top module: `arinc_rx_channel`

## Requirements
- R1: The channel takes one rail sample per clock at the high rate (`rate_lo`=0) and one sample every `LO_DIV` (default 8) clocks at the low rate (`rate_lo`=1). A nominal bit spans 10 samples: 5 with a rail high, then 5 null.
- R2: A bit begins when a sample has one rail high after a null sample. It counts only if the same rail is still high two samples later. A shorter pulse is not a bit.
- R3: With `word25`=0 a word is 32 bits; with `word25`=1 it is 25 bits, and output bits 31:25 read zero. Serial bit k (the first bit is k=1) is stored in word bit k-1. Rail A high means 1 and rail B high means 0.
- R4: With `filt_en`=1 a word is kept only if word bit 8 equals `filt_code[0]` and word bit 9 equals `filt_code[1]`. Any other word is dropped and leaves the buffer and the ready flag untouched.
- R5: `dr_n` goes low when a word enters the buffer. It returns high at the falling edge of an `oe_n` pulse that reads the second of the two halves, in either order. Reading the same half again does not clear it.
- R6: While `dr_n` is low the buffer does not change. An accepted word waits in a side register, and a later accepted word replaces it. The waiting word enters the buffer once `dr_n` is high and `oe_n` is high.
- R7: If 10 consecutive null samples occur after at least one bit of a word but before the full word length has arrived, the partial word is dropped.
- R8: A word is accepted only if at least 10 null samples come before its first bit and 10 null samples follow its last bit. A bit that arrives after the full length but before that trailing null drops the word, and the bits that follow are ignored until the next 10-sample null.
- R9: `parity_err` is 1 when the buffered word holds an even number of ones and 0 when it holds an odd number.
- R10: With `self_test`=1 the channel samples `test_a`/`test_b` and ignores the line rails. When `TEST_INVERT`=1 the test rails are swapped, so the stored word is the complement of the sent one (bits above the word length stay zero).
- R11: A sample with both rails high aborts the current word. Bits are ignored until the next 10-sample null.
- R12: While `oe_n` is low, `data_drive` is 1 and `data_out` carries word bits 15:0 (`sel`=0) or 31:16 (`sel`=1). While `oe_n` is high, `data_drive` is 0 and `data_out` is zero.
- R13: After reset `dr_n` is 1, the buffer is zero and no word is waiting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| rate_lo | input | 1 | 0: high bit rate, 1: low bit rate |
| word25 | input | 1 | 0: 32-bit words, 1: 25-bit words |
| filt_en | input | 1 | Enables the code filter |
| filt_code | input | 2 | Expected values of word bits 9 (bit 1) and 8 (bit 0) |
| self_test | input | 1 | Selects the wrap-around test rails |
| line_a | input | 1 | Line rail for data ones |
| line_b | input | 1 | Line rail for data zeros |
| test_a | input | 1 | Test rail for data ones |
| test_b | input | 1 | Test rail for data zeros |
| sel | input | 1 | Half select: 0 lower, 1 upper |
| oe_n | input | 1 | Active-low read enable |
| data_out | output | 16 | Selected half of the buffered word |
| data_drive | output | 1 | High while the data bus should be driven |
| dr_n | output | 1 | Active-low data-ready flag |
| parity_err | output | 1 | 1 when the buffered word has an even number of ones |

## Verification
The bench targets the edges of the framing logic. It sends words cut short by a long null, words with one extra bit and no trailing gap, words hit by a both-rails-high sample, and a one-sample glitch inside a bit's null half. A design that framed words carelessly would latch a truncated or shifted word, or would lose the good word that carries the glitch. The ready and side-register handshake is driven with words that arrive while the buffer is full. A design that overwrote the buffer, dropped the waiting word, or cleared ready after one half would return the wrong word on the next read. A sweep over all four filter codes against all four values of bits 9 and 10 catches a swapped or mis-positioned comparison. A second instance with inverted test rails catches a wrap-around path that passes data through unchanged.

// File: rtl/arinc_rx_pkg.sv
package arinc_rx_pkg;

    localparam int WORD_MAX = 32;
    localparam int HALF_W   = 16;
    localparam int CODE_POS = 8;

    typedef enum logic [1:0] {
        RAIL_NULL = 2'b00,
        RAIL_ZERO = 2'b01,
        RAIL_ONE  = 2'b10,
        RAIL_ERR  = 2'b11
    } rail_e;

    typedef struct packed {
        logic bit_stb;
        logic bit_val;
        logic gap_stb;
        logic err_stb;
    } sym_t;

    function automatic rail_e rail_decode(input logic a, input logic b);
        return rail_e'({a, b});
    endfunction

    function automatic logic even_ones(input logic [WORD_MAX-1:0] w);
        return ~(^w);
    endfunction

endpackage

// File: rtl/arinc_rx_tick.sv
module arinc_rx_tick #(
    parameter int HI_DIV = 1,
    parameter int LO_DIV = 8
) (
    input  logic clk,
    input  logic rst,
    input  logic rate_lo,
    output logic tick
);
    localparam int CW = $clog2(LO_DIV + HI_DIV + 1);

    logic [CW-1:0] cnt;
    logic [CW-1:0] limit;

    assign limit = rate_lo ? CW'(LO_DIV - 1) : CW'(HI_DIV - 1);
    assign tick  = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (cnt >= limit) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/arinc_rx_bitdet.sv
module arinc_rx_bitdet
    import arinc_rx_pkg::*;
#(
    parameter int SPB     = 10,
    parameter int CONFIRM = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic rail_a,
    input  logic rail_b,
    output sym_t sym
);
    localparam int NW = $clog2(SPB + 1);
    localparam int PW = $clog2(CONFIRM + 1);

    rail_e         cur;
    logic          prev_null;
    logic          pend;
    logic          pend_one;
    logic [PW-1:0] pend_cnt;
    logic [NW-1:0] null_cnt;

    assign cur = rail_decode(rail_a, rail_b);

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_null <= 1'b0;
            pend      <= 1'b0;
            pend_one  <= 1'b0;
            pend_cnt  <= '0;
            null_cnt  <= '0;
            sym       <= '0;
        end else begin
            sym <= '0;
            if (tick) begin
                prev_null <= (cur == RAIL_NULL);
                // idle tracking
                if (cur == RAIL_NULL) begin
                    if (null_cnt != NW'(SPB)) null_cnt <= null_cnt + 1'b1;
                    if (null_cnt == NW'(SPB - 1)) sym.gap_stb <= 1'b1;
                end else begin
                    null_cnt <= '0;
                end
                // bit start and confirmation
                if (cur == RAIL_ERR) begin
                    sym.err_stb <= 1'b1;
                    pend        <= 1'b0;
                end else if (pend) begin
                    if (pend_cnt == '0) begin
                        pend <= 1'b0;
                        if (cur == (pend_one ? RAIL_ONE : RAIL_ZERO)) begin
                            sym.bit_stb <= 1'b1;
                            sym.bit_val <= pend_one;
                        end
                    end else begin
                        pend_cnt <= pend_cnt - 1'b1;
                    end
                end else if (prev_null && cur != RAIL_NULL) begin
                    pend     <= 1'b1;
                    pend_one <= (cur == RAIL_ONE);
                    pend_cnt <= PW'(CONFIRM - 1);
                end
            end
        end
    end
endmodule

// File: rtl/arinc_rx_framer.sv
module arinc_rx_framer
    import arinc_rx_pkg::*;
#(
    parameter int SHORT_LEN = 25
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                word25,
    input  sym_t                sym,
    output logic                word_stb,
    output logic [WORD_MAX-1:0] word
);
    localparam int LW = $clog2(WORD_MAX + 1);
    localparam int IW = $clog2(WORD_MAX);

    logic [LW-1:0]       cnt;
    logic [LW-1:0]       len;
    logic                armed;
    logic [WORD_MAX-1:0] shreg;

    assign len = word25 ? LW'(SHORT_LEN) : LW'(WORD_MAX);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt      <= '0;
            armed    <= 1'b0;
            shreg    <= '0;
            word_stb <= 1'b0;
            word     <= '0;
        end else begin
            word_stb <= 1'b0;
            if (sym.err_stb) begin
                cnt   <= '0;
                armed <= 1'b0;
            end else if (sym.gap_stb) begin
                if (armed && cnt == len) begin
                    word_stb <= 1'b1;
                    word     <= shreg;
                end
                cnt   <= '0;
                armed <= 1'b1;
            end else if (sym.bit_stb && armed) begin
                if (cnt == len) begin
                    cnt   <= '0;
                    armed <= 1'b0;
                end else begin
                    if (cnt == '0) begin
                        shreg <= {{(WORD_MAX-1){1'b0}}, sym.bit_val};
                    end else begin
                        shreg[cnt[IW-1:0]] <= sym.bit_val;
                    end
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/arinc_rx_hostbuf.sv
module arinc_rx_hostbuf
    import arinc_rx_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                word_stb,
    input  logic [WORD_MAX-1:0] word,
    input  logic                filt_en,
    input  logic [1:0]          filt_code,
    input  logic                sel,
    input  logic                oe_n,
    output logic [WORD_MAX-1:0] out_word,
    output logic                dr_n
);
    logic [WORD_MAX-1:0] held;
    logic                held_v;
    logic                oe_q;
    logic                rd_lo;
    logic                rd_hi;
    logic                match;
    logic                oe_fall;
    logic                load;

    assign match   = !filt_en || (word[CODE_POS+1:CODE_POS] == filt_code);
    assign oe_fall = oe_q && !oe_n;
    assign load    = held_v && dr_n && oe_n;

    always_ff @(posedge clk) begin
        if (rst) begin
            held     <= '0;
            held_v   <= 1'b0;
            oe_q     <= 1'b1;
            rd_lo    <= 1'b0;
            rd_hi    <= 1'b0;
            out_word <= '0;
            dr_n     <= 1'b1;
        end else begin
            oe_q <= oe_n;
            if (load) begin
                out_word <= held;
                dr_n     <= 1'b0;
                rd_lo    <= 1'b0;
                rd_hi    <= 1'b0;
            end else if (oe_fall && !dr_n) begin
                if (sel ? rd_lo : rd_hi) begin
                    dr_n  <= 1'b1;
                    rd_lo <= 1'b0;
                    rd_hi <= 1'b0;
                end else if (sel) begin
                    rd_hi <= 1'b1;
                end else begin
                    rd_lo <= 1'b1;
                end
            end
            if (word_stb && match) begin
                held   <= word;
                held_v <= 1'b1;
            end else if (load) begin
                held_v <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/arinc_rx_channel.sv
module arinc_rx_channel
    import arinc_rx_pkg::*;
#(
    parameter int HI_DIV          = 1,
    parameter int LO_DIV          = 8,
    parameter int SAMPLES_PER_BIT = 10,
    parameter int CONFIRM_TICKS   = 2,
    parameter int SHORT_LEN       = 25,
    parameter bit TEST_INVERT     = 1'b0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rate_lo,
    input  logic              word25,
    input  logic              filt_en,
    input  logic [1:0]        filt_code,
    input  logic              self_test,
    input  logic              line_a,
    input  logic              line_b,
    input  logic              test_a,
    input  logic              test_b,
    input  logic              sel,
    input  logic              oe_n,
    output logic [HALF_W-1:0] data_out,
    output logic              data_drive,
    output logic              dr_n,
    output logic              parity_err
);
    logic                tick;
    logic                tst_a;
    logic                tst_b;
    logic                rail_a;
    logic                rail_b;
    sym_t                sym;
    logic                word_stb;
    logic [WORD_MAX-1:0] word;
    logic [WORD_MAX-1:0] out_word;

    generate
        if (TEST_INVERT) begin : g_swap
            assign tst_a = test_b;
            assign tst_b = test_a;
        end else begin : g_pass
            assign tst_a = test_a;
            assign tst_b = test_b;
        end
    endgenerate

    assign rail_a = self_test ? tst_a : line_a;
    assign rail_b = self_test ? tst_b : line_b;

    arinc_rx_tick #(
        .HI_DIV (HI_DIV),
        .LO_DIV (LO_DIV)
    ) u_tick (
        .clk     (clk),
        .rst     (rst),
        .rate_lo (rate_lo),
        .tick    (tick)
    );

    arinc_rx_bitdet #(
        .SPB     (SAMPLES_PER_BIT),
        .CONFIRM (CONFIRM_TICKS)
    ) u_bitdet (
        .clk    (clk),
        .rst    (rst),
        .tick   (tick),
        .rail_a (rail_a),
        .rail_b (rail_b),
        .sym    (sym)
    );

    arinc_rx_framer #(
        .SHORT_LEN (SHORT_LEN)
    ) u_framer (
        .clk      (clk),
        .rst      (rst),
        .word25   (word25),
        .sym      (sym),
        .word_stb (word_stb),
        .word     (word)
    );

    arinc_rx_hostbuf u_hostbuf (
        .clk       (clk),
        .rst       (rst),
        .word_stb  (word_stb),
        .word      (word),
        .filt_en   (filt_en),
        .filt_code (filt_code),
        .sel       (sel),
        .oe_n      (oe_n),
        .out_word  (out_word),
        .dr_n      (dr_n)
    );

    assign data_drive = !oe_n;
    assign data_out   = oe_n ? '0
                      : (sel ? out_word[WORD_MAX-1:HALF_W] : out_word[HALF_W-1:0]);
    assign parity_err = even_ones(out_word);
endmodule

// File: rtl/arinc_rx_channel_chk.sv
module arinc_rx_channel_chk
    import arinc_rx_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                oe_n,
    input logic                dr_n,
    input logic [HALF_W-1:0]   data_out,
    input logic [WORD_MAX-1:0] out_word,
    input sym_t                sym,
    input logic                word_stb
);
    AST_BUS_QUIET_WHEN_OFF: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> (data_out == '0)); // R12

    AST_READY_HOLDS_UNREAD: assert property (@(posedge clk) disable iff (rst)
        (!dr_n && oe_n) |=> !dr_n); // R5

    AST_READY_RISES_ON_READ: assert property (@(posedge clk) disable iff (rst)
        $rose(dr_n) |-> !$past(oe_n)); // R5

    AST_BUFFER_FROZEN: assert property (@(posedge clk) disable iff (rst)
        !dr_n |=> $stable(out_word)); // R6

    AST_WORD_NEEDS_GAP: assert property (@(posedge clk) disable iff (rst)
        word_stb |-> $past(sym.gap_stb)); // R8

    AST_ONE_SYMBOL_KIND: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sym.bit_stb, sym.gap_stb, sym.err_stb})); // R11
endmodule

bind arinc_rx_channel arinc_rx_channel_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .oe_n     (oe_n),
    .dr_n     (dr_n),
    .data_out (data_out),
    .out_word (out_word),
    .sym      (sym),
    .word_stb (word_stb)
);

// File: tb/test_arinc_rx_channel.sv
module test_arinc_rx_channel;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        rate_lo = 1'b0;
    logic        word25 = 1'b0;
    logic        filt_en = 1'b0;
    logic [1:0]  filt_code = 2'b00;
    logic        self_test = 1'b0;
    logic        line_a = 1'b0;
    logic        line_b = 1'b0;
    logic        test_a = 1'b0;
    logic        test_b = 1'b0;
    logic        sel = 1'b0;
    logic        oe_n = 1'b1;
    logic [15:0] data_out;
    logic [15:0] inv_data;
    logic        data_drive;
    logic        inv_drive;
    logic        dr_n;
    logic        inv_dr_n;
    logic        parity_err;
    logic        inv_parity;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;
    bit route_test = 1'b0;

    always #2 clk = ~clk;

    arinc_rx_channel i_arinc_rx_channel (
        .clk(clk), .rst(rst), .rate_lo(rate_lo), .word25(word25),
        .filt_en(filt_en), .filt_code(filt_code), .self_test(self_test),
        .line_a(line_a), .line_b(line_b), .test_a(test_a), .test_b(test_b),
        .sel(sel), .oe_n(oe_n), .data_out(data_out), .data_drive(data_drive),
        .dr_n(dr_n), .parity_err(parity_err)
    );

    arinc_rx_channel #(.TEST_INVERT(1'b1)) i_inv (
        .clk(clk), .rst(rst), .rate_lo(rate_lo), .word25(word25),
        .filt_en(filt_en), .filt_code(filt_code), .self_test(self_test),
        .line_a(line_a), .line_b(line_b), .test_a(test_a), .test_b(test_b),
        .sel(sel), .oe_n(oe_n), .data_out(inv_data), .data_drive(inv_drive),
        .dr_n(inv_dr_n), .parity_err(inv_parity)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] fit(input logic [31:0] w, input int n);
        return (n == 25) ? (w & 32'h01FF_FFFF) : w;
    endfunction

    task automatic put(input logic a, input logic b, input int ticks);
        if (route_test) begin
            test_a = a; test_b = b;
        end else begin
            line_a = a; line_b = b;
        end
        repeat (ticks * (rate_lo ? 8 : 1)) @(negedge clk);
    endtask

    task automatic send_bit(input logic v);
        put(v, !v, 5);
        put(1'b0, 1'b0, 5);
    endtask

    task automatic idle();
        put(1'b0, 1'b0, 20);
    endtask

    task automatic send_word(input logic [31:0] w, input int n);
        for (int i = 0; i < n; i++) send_bit(w[i]);
        idle();
    endtask

    task automatic read_half(input logic s, output logic [15:0] d, output logic [15:0] di,
                             output logic rdy, output logic drv);
        @(negedge clk);
        sel = s; oe_n = 1'b0;
        repeat (2) @(negedge clk);
        d = data_out; di = inv_data; rdy = dr_n; drv = data_drive;
        oe_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // reads lower then upper; checks ready behaviour and data of both instances
    task automatic expect_word(input logic [31:0] exp, input logic [31:0] exp_inv,
                               input string req);
        logic [15:0] lo, hi, ilo, ihi;
        logic r1, r2, d1, d2;
        check(dr_n == 1'b0, {req, " ready low"}, {31'd0, dr_n}, 32'd0);
        check(parity_err == ~(^exp), "R9 parity status", {31'd0, parity_err}, {31'd0, ~(^exp)});
        read_half(1'b0, lo, ilo, r1, d1);
        read_half(1'b1, hi, ihi, r2, d2);
        check({hi, lo} == exp, req, {hi, lo}, exp);
        check({ihi, ilo} == exp_inv, {req, " inverted instance"}, {ihi, ilo}, exp_inv);
        check(r1 == 1'b0 && r2 == 1'b1, "R5 ready clears on second half",
              {30'd0, r1, r2}, 32'd1);
        check(d1 && d2, "R12 drive during read", {30'd0, d1, d2}, 32'd3);
    endtask

    task automatic expect_empty(input string req);
        check(dr_n == 1'b1, req, {31'd0, dr_n}, 32'd1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] w;
        logic [15:0] d, di;
        logic rdy, drv;

        repeat (5) @(negedge clk);
        // R13 reset state, R12 bus quiet
        check(dr_n == 1'b1, "R13 reset ready", {31'd0, dr_n}, 32'd1);
        check(data_drive == 1'b0 && data_out == 16'h0, "R12 quiet after reset",
              {15'd0, data_drive, data_out}, 32'd0);
        rst = 1'b0;
        idle();
        read_half(1'b0, d, di, rdy, drv);
        check(d == 16'h0, "R13 buffer zero after reset", {16'd0, d}, 32'd0);

        // R3 32-bit words, fixed patterns and walking one
        foreach (w[i]) begin end
        send_word(32'hA5A5_5A5A, 32); expect_word(32'hA5A5_5A5A, 32'hA5A5_5A5A, "R3 word pattern");
        send_word(32'hFFFF_FFFF, 32); expect_word(32'hFFFF_FFFF, 32'hFFFF_FFFF, "R3 all ones");
        send_word(32'h0000_0000, 32); expect_word(32'h0, 32'h0, "R3 all zeros");
        send_word(32'h1234_5678, 32); expect_word(32'h1234_5678, 32'h1234_5678, "R3 count pattern");
        for (int k = 0; k < 32; k++) begin
            w = 32'h1 << k;
            send_word(w, 32);
            expect_word(w, w, "R3 walking one");
        end

        // R3 25-bit words
        word25 = 1'b1;
        send_word(32'hFFFF_FFFF, 25); expect_word(32'h01FF_FFFF, 32'h01FF_FFFF, "R3 short all ones");
        send_word(32'h00AA_AAAA, 25); expect_word(32'h00AA_AAAA, 32'h00AA_AAAA, "R3 short pattern");
        send_word(32'h0123_4567, 25); expect_word(fit(32'h0123_4567, 25), fit(32'h0123_4567, 25), "R3 short count");
        send_word(32'hFFFF_FFFF, 32); expect_empty("R8 overlong in short mode");
        word25 = 1'b0;

        // R4 filter sweep over codes and bit 9/10 values
        filt_en = 1'b1;
        for (int c = 0; c < 4; c++) begin
            for (int p = 0; p < 4; p++) begin
                filt_code = c[1:0];
                w = 32'h3C00_00C3 | (32'(p) << 8);
                send_word(w, 32);
                if (p == c) expect_word(w, w, "R4 code match");
                else expect_empty("R4 code mismatch dropped");
            end
        end
        filt_en = 1'b0;

        // R5 upper half first, repeated half does not clear
        send_word(32'hBEEF_CAFE, 32);
        read_half(1'b1, d, di, rdy, drv);
        check(d == 16'hBEEF && rdy == 1'b0, "R5 upper first", {d, 15'd0, rdy}, 32'hBEEF_0000);
        read_half(1'b1, d, di, rdy, drv);
        check(rdy == 1'b0, "R5 same half twice keeps ready", {31'd0, rdy}, 32'd0);
        read_half(1'b0, d, di, rdy, drv);
        check(d == 16'hCAFE && rdy == 1'b1, "R5 lower second clears", {d, 15'd0, rdy}, 32'hCAFE_0001);
        check(data_drive == 1'b0 && data_out == 16'h0, "R12 quiet after read",
              {15'd0, data_drive, data_out}, 32'd0);

        // R6 waiting word and overwrite
        send_word(32'h1111_2222, 32);
        send_word(32'h3333_4444, 32);
        check(dr_n == 1'b0, "R6 ready stays low", {31'd0, dr_n}, 32'd0);
        expect_word(32'h1111_2222, 32'h1111_2222, "R6 first word kept");
        expect_word(32'h3333_4444, 32'h3333_4444, "R6 waiting word moves in");
        expect_empty("R6 nothing left");
        send_word(32'h5555_0001, 32);
        send_word(32'h6666_0002, 32);
        send_word(32'h7777_0003, 32);
        expect_word(32'h5555_0001, 32'h5555_0001, "R6 buffer not overwritten");
        expect_word(32'h7777_0003, 32'h7777_0003, "R6 latest waiting word");
        expect_empty("R6 overwritten word gone");

        // R7 broken word
        send_word(32'h0000_03FF, 10);
        expect_empty("R7 partial word dropped");
        send_word(32'h0F0F_F0F0, 32); expect_word(32'h0F0F_F0F0, 32'h0F0F_F0F0, "R7 recovery");

        // R8 extra bit without trailing gap
        for (int i = 0; i < 33; i++) send_bit(1'b1);
        idle();
        expect_empty("R8 missing trailing null");
        send_word(32'h8001_8001, 32); expect_word(32'h8001_8001, 32'h8001_8001, "R8 recovery");

        // R11 both rails high inside a word
        w = 32'hDEAD_BEEF;
        for (int i = 0; i < 32; i++) begin
            if (i == 12) begin
                put(w[i], !w[i], 5);
                put(1'b0, 1'b0, 2);
                put(1'b1, 1'b1, 1);
                put(1'b0, 1'b0, 2);
            end else begin
                send_bit(w[i]);
            end
        end
        idle();
        expect_empty("R11 rail error drops word");
        send_word(w, 32); expect_word(w, w, "R11 recovery");

        // R2 one-sample glitch inside a null half
        w = 32'h2468_ACE1;
        for (int i = 0; i < 32; i++) begin
            if (i == 7) begin
                put(w[i], !w[i], 5);
                put(1'b0, 1'b0, 1);
                put(1'b1, 1'b0, 1);
                put(1'b0, 1'b0, 3);
            end else begin
                send_bit(w[i]);
            end
        end
        idle();
        expect_word(w, w, "R2 glitch is not a bit");

        // R1 low rate
        rate_lo = 1'b1;
        idle();
        send_word(32'h9ABC_DEF0, 32); expect_word(32'h9ABC_DEF0, 32'h9ABC_DEF0, "R1 low rate word");
        rate_lo = 1'b0;
        idle();

        // R10 wrap-around test path
        self_test = 1'b1;
        route_test = 1'b1;
        idle();
        send_word(32'h0F00_1234, 32);
        expect_word(32'h0F00_1234, ~32'h0F00_1234, "R10 test path");
        word25 = 1'b1;
        send_word(32'h0055_AA11, 25);
        expect_word(32'h0055_AA11, fit(~32'h0055_AA11, 25), "R10 test path short");
        word25 = 1'b0;
        route_test = 1'b0;
        send_word(32'h7E7E_7E7E, 32);
        expect_empty("R10 line ignored in test mode");
        self_test = 1'b0;
        idle();
        send_word(32'h4321_8765, 32); expect_word(32'h4321_8765, 32'h4321_8765, "R10 back to line");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule